// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It does this by walking a two-level page table that lives in word-addressed memory. A requester presents a virtual address, an access kind (read, write or execute) and the physical base of the top-level directory. The walker fetches one directory word and then one leaf word through a single memory port. It checks the valid and permission bits. On a permitted write to a page that is not yet dirty, it writes the leaf word back with the dirty bit set. It then reports either a physical address or a fault code.

Pages are 4 KB. The virtual address splits into three fields, from most to least significant: a 10-bit directory index, a 10-bit leaf-table index and a 12-bit page offset. Both tables hold 1024 word-sized entries.

Only one walk is in flight at a time. The request side stays not-ready from acceptance until the result cycle. The memory side is a valid/ready request channel with a one-cycle response strobe. Its latency may vary, and every request, writes included, gets exactly one response.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, the walker is ready for a request (`req_ready`=1), `done_valid`=0 and `mem_req_valid`=0.
- R2: The first memory access of a walk is a read (`mem_req_we`=0) at address `req_base` + 4 × `req_vaddr[31:22]`.
- R3: When the directory word is valid, the second access is a read at `{dir_word[31:12], 12'h000}` + 4 × `req_vaddr[21:12]`.
- R4: A successful walk ends with exactly one cycle of `done_valid`=1, `done_fault`=0 (ok), and `done_paddr` = `{leaf_word[31:12], req_vaddr[11:0]}`.
- R5: Entry layout: page number in bits 31:12, valid in bit 0, read in bit 1, write in bit 2, execute in bit 3, dirty in bit 4. If the directory word has bit 0 clear, the walk ends with `done_fault`=1 (page fault) and `done_paddr`=0, and no leaf read is issued.
- R6: If the leaf word has bit 0 clear, the walk ends with `done_fault`=1 and `done_paddr`=0, whatever its permission bits.
- R7: Access codes are 0 read, 1 write, 2 execute; each needs leaf bit 1, 2 or 3 respectively. A valid leaf without the needed bit, or access code 3, ends the walk with `done_fault`=2 (protection fault) and `done_paddr`=0.
- R8: A permitted write to a leaf whose dirty bit is clear issues one memory write to the leaf's address, with data equal to the leaf word with bit 4 set, and completes only after that write's response. Reads, executes, faults and writes to already-dirty leaves issue no write.
- R9: `req_ready` is high only while idle; it stays low from acceptance through the cycle with `done_valid`, and is high again the cycle after.
- R10: A memory request keeps `mem_req_valid`, address, write flag and write data stable until `mem_req_ready`, and no new request is raised while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_base | input | 32 | Physical base of the directory |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | 32 | Word byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | One-cycle response strobe |
| mem_rsp_rdata | input | 32 | Read data with the response |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| done_paddr | output | 32 | Physical address, 0 on a fault |

## Verification
Address-formation errors in internal state show up as a wrong address on the memory port in the very cycle that request is raised, so the bench compares every request address against a value it computes itself. A wrong index slice or a stale latched base therefore fails one request into the walk. Control-state errors are more varied. A lost response or a skipped state hangs the walk or cuts it short, which shows as a missing or early result strobe and a wrong count of memory accesses. A wrong permission or dirty decision shows only at the end of the walk, as a wrong fault code, a missing or extra write, or wrong write data. Stalled-acceptance and variable-latency patterns are used so that a request dropped before its handshake is visible.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;
  // entry flag positions
  localparam int unsigned FLG_VALID = 0;
  localparam int unsigned FLG_RD    = 1;
  localparam int unsigned FLG_WR    = 2;
  localparam int unsigned FLG_EX    = 3;
  localparam int unsigned FLG_DIRTY = 4;

  // access kinds
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  // result codes
  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_PAGE = 2'd1;
  localparam logic [1:0] RES_PROT = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_MARK_REQ,
    ST_MARK_WAIT,
    ST_RESULT
  } walk_st_e;
endpackage

// File: rtl/pt_addr_gen.sv
`timescale 1ns/1ps
// Address arithmetic for both table levels and the final physical address.
module pt_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int TBL_W     = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic [ADDR_W-1:0]       vaddr,
  input  logic [ADDR_W-OFF_W-1:0] ent_ppn,
  output logic [ADDR_W-1:0]       dir_addr,
  output logic [ADDR_W-1:0]       leaf_addr,
  output logic [ADDR_W-1:0]       phys_addr
);
  localparam int PPN_W = ADDR_W - OFF_W;
  localparam int DIR_W = ADDR_W - OFF_W - TBL_W;
  localparam int SH    = $clog2(ENT_BYTES);

  logic [DIR_W-1:0]  dir_idx;
  logic [TBL_W-1:0]  tbl_idx;
  logic [ADDR_W-1:0] dir_off;
  logic [ADDR_W-1:0] tbl_off;
  logic [ADDR_W-1:0] tbl_base;

  always_comb begin
    dir_idx  = vaddr[ADDR_W-1 -: DIR_W];
    tbl_idx  = vaddr[OFF_W+TBL_W-1 -: TBL_W];
    dir_off  = {{(ADDR_W-DIR_W){1'b0}}, dir_idx} << SH;
    tbl_off  = {{(ADDR_W-TBL_W){1'b0}}, tbl_idx} << SH;
    tbl_base = {ent_ppn, {OFF_W{1'b0}}};
    dir_addr  = base + dir_off;
    leaf_addr = tbl_base + tbl_off;
    phys_addr = {ent_ppn[PPN_W-1:0], vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/pt_perm_check.sv
`timescale 1ns/1ps
// Decodes a fetched entry: presence, access permission, dirty update.
module pt_perm_check
  import pt_walker_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [1:0]       acc,
  input  logic [ENT_W-1:0] entry,
  output logic             present,
  output logic             allowed,
  output logic             want_mark,
  output logic [ENT_W-1:0] marked_entry
);
  always_comb begin
    present = entry[FLG_VALID];
    unique case (acc)
      ACC_READ:  allowed = entry[FLG_RD];
      ACC_WRITE: allowed = entry[FLG_WR];
      ACC_EXEC:  allowed = entry[FLG_EX];
      default:   allowed = 1'b0;
    endcase
    want_mark    = (acc == ACC_WRITE) && !entry[FLG_DIRTY];
    marked_entry = entry | (ENT_W'(1) << FLG_DIRTY);
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
`timescale 1ns/1ps
// Walk sequencer: request capture, memory port, result registers.
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [ADDR_W-1:0] req_base,
  output logic              req_ready,
  output logic              sel_live,
  output logic [ADDR_W-1:0] vaddr_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [1:0]        acc_q,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [ADDR_W-1:0] leaf_addr,
  input  logic [ADDR_W-1:0] phys_addr,
  input  logic              ent_present,
  input  logic              acc_allowed,
  input  logic              want_mark,
  input  logic [ADDR_W-1:0] marked_entry,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              done_valid,
  output logic [1:0]        done_fault,
  output logic [ADDR_W-1:0] done_paddr
);
  walk_st_e          st;
  logic [ADDR_W-1:0] maddr_q;
  logic [ADDR_W-1:0] mwdata_q;
  logic              mwe_q;
  logic [1:0]        res_q;
  logic [ADDR_W-1:0] paddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      vaddr_q  <= '0;
      base_q   <= '0;
      acc_q    <= ACC_READ;
      maddr_q  <= '0;
      mwdata_q <= '0;
      mwe_q    <= 1'b0;
      res_q    <= RES_OK;
      paddr_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            base_q  <= req_base;
            acc_q   <= req_acc;
            maddr_q <= dir_addr;
            mwe_q   <= 1'b0;
            res_q   <= RES_OK;
            paddr_q <= '0;
            st      <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_req_ready) st <= ST_DIR_WAIT;
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              res_q <= RES_PAGE;
              st    <= ST_RESULT;
            end else begin
              maddr_q <= leaf_addr;
              st      <= ST_LEAF_REQ;
            end
          end
        end
        ST_LEAF_REQ: if (mem_req_ready) st <= ST_LEAF_WAIT;
        ST_LEAF_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              res_q <= RES_PAGE;
              st    <= ST_RESULT;
            end else if (!acc_allowed) begin
              res_q <= RES_PROT;
              st    <= ST_RESULT;
            end else begin
              paddr_q <= phys_addr;
              if (want_mark) begin
                mwe_q    <= 1'b1;
                mwdata_q <= marked_entry;
                st       <= ST_MARK_REQ;
              end else begin
                st <= ST_RESULT;
              end
            end
          end
        end
        ST_MARK_REQ: if (mem_req_ready) st <= ST_MARK_WAIT;
        ST_MARK_WAIT: begin
          if (mem_rsp_valid) begin
            mwe_q <= 1'b0;
            st    <= ST_RESULT;
          end
        end
        ST_RESULT: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (st == ST_IDLE);
    sel_live      = (st == ST_IDLE);
    mem_req_valid = (st == ST_DIR_REQ) || (st == ST_LEAF_REQ) || (st == ST_MARK_REQ);
    mem_req_we    = mwe_q;
    mem_req_addr  = maddr_q;
    mem_req_wdata = mwdata_q;
    done_valid    = (st == ST_RESULT);
    done_fault    = res_q;
    done_paddr    = paddr_q;
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int TBL_W     = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [ADDR_W-1:0] req_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_rdata,
  output logic              done_valid,
  output logic [1:0]        done_fault,
  output logic [ADDR_W-1:0] done_paddr
);
  localparam int PPN_W = ADDR_W - OFF_W;

  logic              sel_live;
  logic [ADDR_W-1:0] vaddr_q, base_q;
  logic [1:0]        acc_q;
  logic [ADDR_W-1:0] ag_base, ag_vaddr;
  logic [ADDR_W-1:0] dir_addr, leaf_addr, phys_addr;
  logic              ent_present, acc_allowed, want_mark;
  logic [ADDR_W-1:0] marked_entry;
  logic [PPN_W-1:0]  ent_ppn;

  always_comb begin
    ag_base  = sel_live ? req_base  : base_q;
    ag_vaddr = sel_live ? req_vaddr : vaddr_q;
    ent_ppn  = mem_rsp_rdata[ADDR_W-1:OFF_W];
  end

  pt_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TBL_W(TBL_W), .ENT_BYTES(ENT_BYTES)
  ) u_agen (
    .base(ag_base), .vaddr(ag_vaddr), .ent_ppn(ent_ppn),
    .dir_addr(dir_addr), .leaf_addr(leaf_addr), .phys_addr(phys_addr)
  );

  pt_perm_check #(.ENT_W(ADDR_W)) u_perm (
    .acc(acc_q), .entry(mem_rsp_rdata),
    .present(ent_present), .allowed(acc_allowed),
    .want_mark(want_mark), .marked_entry(marked_entry)
  );

  pt_walk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .req_base(req_base), .req_ready(req_ready),
    .sel_live(sel_live), .vaddr_q(vaddr_q), .base_q(base_q), .acc_q(acc_q),
    .dir_addr(dir_addr), .leaf_addr(leaf_addr), .phys_addr(phys_addr),
    .ent_present(ent_present), .acc_allowed(acc_allowed),
    .want_mark(want_mark), .marked_entry(marked_entry),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .done_valid(done_valid), .done_fault(done_fault), .done_paddr(done_paddr)
  );
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [ADDR_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              done_valid,
  input logic [1:0]        done_fault,
  input logic [ADDR_W-1:0] done_paddr
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pending <= 1'b1;
    else if (mem_rsp_valid) pending <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !pending); // R10
  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> !req_ready); // R9
  AST_READY_AFTER: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> req_ready && !done_valid); // R4
  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |-> !mem_req_valid && !pending); // R9
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_valid && (done_fault != 2'd0) |-> done_paddr == '0); // R5
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_fault != 2'd3); // R7
  AST_MARK_DATA: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we |-> mem_req_wdata[4] && mem_req_wdata[0]); // R8
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .done_valid(done_valid), .done_fault(done_fault), .done_paddr(done_paddr)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [31:0] req_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        done_valid;
  logic [1:0]  done_fault;
  logic [31:0] done_paddr;

  int total = 0;
  int bad = 0;

  // memory model state
  logic [31:0] mem [logic [31:0]];
  int          cfg_stall = 0;
  int          cfg_lat = 0;
  int          n_rd, n_wr, hold_err;
  logic [31:0] rd_addr [4];
  logic [31:0] wr_addr, wr_data;
  logic [31:0] a0, d0;
  logic        w0;

  always #4 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_base(req_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
    .done_fault(done_fault), .done_paddr(done_paddr)
  );

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] dir_at(input logic [31:0] base, input logic [31:0] va);
    return base + ((va >> 22) * 4);
  endfunction

  function automatic logic [31:0] leaf_at(input logic [31:0] de, input logic [31:0] va);
    return (de & 32'hFFFFF000) + (((va >> 12) & 32'h3FF) * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst && mem_req_valid) begin
        a0 = mem_req_addr; w0 = mem_req_we; d0 = mem_req_wdata;
        repeat (cfg_stall) @(negedge clk);
        if (!mem_req_valid || mem_req_addr !== a0 || mem_req_we !== w0 ||
            (w0 && mem_req_wdata !== d0)) hold_err++;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (cfg_lat) @(negedge clk);
        if (w0) begin
          mem[a0] = d0; wr_addr = a0; wr_data = d0; n_wr++;
          mem_rsp_rdata = 32'h0;
        end else begin
          if (n_rd < 4) rd_addr[n_rd] = a0;
          n_rd++;
          mem_rsp_rdata = mrd(a0);
        end
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base,
                      output logic [31:0] pa, output logic [1:0] flt);
    bit ready_leak = 0;
    n_rd = 0; n_wr = 0; hold_err = 0;
    @(negedge clk);
    chk("R9 ready while idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_valid) begin
      if (req_ready) ready_leak = 1;
      @(negedge clk);
    end
    pa = done_paddr; flt = done_fault;
    chk("R9 not ready during walk", {31'b0, ready_leak | req_ready}, 32'd0);
    @(negedge clk);
    chk("R4 single result pulse", {31'b0, done_valid}, 32'd0);
    chk("R9 ready after result", {31'b0, req_ready}, 32'd1);
    chk("R10 request held until accepted", hold_err, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1 no result after reset", {31'b0, done_valid}, 32'd0);
    chk("R1 no memory request after reset", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_write_example();
    logic [31:0] pa; logic [1:0] f;
    logic [31:0] b = 32'h10005000, va = 32'h7192a44c;
    logic [31:0] de = 32'h12345001, le = 32'h14817007;
    mem[dir_at(b, va)] = de; mem[leaf_at(de, va)] = le;
    cfg_stall = 1; cfg_lat = 2;
    walk(va, 2'd1, b, pa, f);
    chk("R4 write paddr", pa, 32'h1481744c);
    chk("R4 write code", {30'b0, f}, 32'd0);
    chk("R2 dir address", rd_addr[0], 32'h10005718);
    chk("R3 leaf address", rd_addr[1], 32'h123454A8);
    chk("R8 one write", n_wr, 1);
    chk("R8 write address", wr_addr, 32'h123454A8);
    chk("R8 write data", wr_data, 32'h14817017);
  endtask

  task automatic t_read_ok();
    logic [31:0] pa; logic [1:0] f;
    logic [31:0] b = 32'h00200000, va = 32'h00403ABC;
    logic [31:0] de = 32'h00456001, le = 32'h0ABCD003;
    mem[dir_at(b, va)] = de; mem[leaf_at(de, va)] = le;
    cfg_stall = 3; cfg_lat = 0;
    walk(va, 2'd0, b, pa, f);
    chk("R4 read paddr", pa, 32'h0ABCDABC);
    chk("R4 read code", {30'b0, f}, 32'd0);
    chk("R2 dir address read", rd_addr[0], 32'h00200004);
    chk("R3 leaf address read", rd_addr[1], 32'h0045600C);
    chk("R8 no write on read", n_wr, 0);
  endtask

  task automatic t_exec_edge();
    logic [31:0] pa; logic [1:0] f;
    logic [31:0] b = 32'h00300000, va = 32'hFFFFF123;
    logic [31:0] de = 32'h00777001, le = 32'h00ABC009;
    mem[dir_at(b, va)] = de; mem[leaf_at(de, va)] = le;
    cfg_stall = 0; cfg_lat = 4;
    walk(va, 2'd2, b, pa, f);
    chk("R4 exec paddr", pa, 32'h00ABC123);
    chk("R2 top dir index", rd_addr[0], 32'h00300FFC);
    chk("R3 top leaf index", rd_addr[1], 32'h00777FFC);
    chk("R8 no write on exec", n_wr, 0);
  endtask

  task automatic t_dir_invalid();
    logic [31:0] pa; logic [1:0] f;
    logic [31:0] b = 32'h00500000, va = 32'h80001000;
    mem[dir_at(b, va)] = 32'h1200001E;
    cfg_stall = 2; cfg_lat = 1;
    walk(va, 2'd0, b, pa, f);
    chk("R5 dir page fault code", {30'b0, f}, 32'd1);
    chk("R5 dir fault paddr zero", pa, 32'h0);
    chk("R5 no leaf read", n_rd, 1);
  endtask

  task automatic t_leaf_invalid();
    logic [31:0] pa; logic [1:0] f;
    logic [31:0] b = 32'h00600000, va = 32'h00802000;
    logic [31:0] de = 32'h00880001;
    mem[dir_at(b, va)] = de; mem[leaf_at(de, va)] = 32'h0000F00E;
    cfg_stall = 0; cfg_lat = 0;
    walk(va, 2'd1, b, pa, f);
    chk("R6 leaf page fault code", {30'b0, f}, 32'd1);
    chk("R6 leaf fault paddr zero", pa, 32'h0);
    chk("R8 no write on fault", n_wr, 0);
    mem[leaf_at(de, va)] = 32'h33333000;
    walk(va, 2'd0, b, pa, f);
    chk("R6 page fault over protection", {30'b0, f}, 32'd1);
  endtask

  task automatic t_protect();
    logic [31:0] pa; logic [1:0] f;
    logic [31:0] b = 32'h00700000, va = 32'h01005040;
    logic [31:0] de = 32'h00990001;
    cfg_stall = 1; cfg_lat = 1;
    mem[dir_at(b, va)] = de;
    mem[leaf_at(de, va)] = 32'h22222019;
    walk(va, 2'd0, b, pa, f);
    chk("R7 read denied", {30'b0, f}, 32'd2);
    chk("R7 denied paddr zero", pa, 32'h0);
    walk(va, 2'd1, b, pa, f);
    chk("R7 write denied", {30'b0, f}, 32'd2);
    chk("R8 no write when denied", n_wr, 0);
    mem[leaf_at(de, va)] = 32'h22222003;
    walk(va, 2'd2, b, pa, f);
    chk("R7 exec denied", {30'b0, f}, 32'd2);
    mem[leaf_at(de, va)] = 32'h2222201F;
    walk(va, 2'd3, b, pa, f);
    chk("R7 code 3 denied", {30'b0, f}, 32'd2);
  endtask

  task automatic t_already_dirty();
    logic [31:0] pa; logic [1:0] f;
    logic [31:0] b = 32'h00800000, va = 32'h02006777;
    logic [31:0] de = 32'h00AA0001;
    mem[dir_at(b, va)] = de; mem[leaf_at(de, va)] = 32'h5555501F;
    cfg_stall = 0; cfg_lat = 3;
    walk(va, 2'd1, b, pa, f);
    chk("R8 dirty write ok code", {30'b0, f}, 32'd0);
    chk("R8 no write when already dirty", n_wr, 0);
    chk("R4 dirty write paddr", pa, 32'h55555777);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_example();
    t_read_ok();
    t_exec_edge();
    t_dir_invalid();
    t_leaf_invalid();
    t_protect();
    t_already_dirty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule